// File: doc/BRIEF.md
# Rate-Proportional Spike Train Encoder

This block turns a frame of non-negative sample values, one per channel, into one binary spike train per channel. A frame is loaded value by value over a valid/ready stream after a start strobe. The block adds up the frame. It then gives each channel a share of a fixed spike budget, in proportion to that channel's part of the frame total. The result is rounded to the nearest integer, with ties rounded up, and capped at the window length.

Once every count is known, the block plays out a window of `NT` consecutive slots, one per clock. Each channel drops its spikes into slots picked by selection sampling, which draws from a per-channel pseudo-random generator. Because of this sampling, the number of spikes a channel emits always equals its count exactly. A seed input makes a run repeatable. A one-cycle done flag closes each window, and a new frame can be started after it.

Top module: `rate_spike_encoder`

## Requirements
- R1: After synchronous reset, `in_ready`, `spike_valid` and `window_done` are low and `spike` is all-zero.
- R2: A `start` pulse is taken only while the block is idle. After it, `in_ready` stays high until exactly `N_CH` values have been transferred (`in_valid && in_ready`), filling channels 0 first up to `N_CH-1` last. A `start` pulse or `in_valid` seen in any other phase has no effect.
- R3: With S the sum of the frame, channel i emits floor((NS*v_i + floor(S/2)) / S) spikes in the window. This is round-half-up of NS*v_i/S.
- R4: A channel whose count from R3 exceeds `NT` emits exactly `NT` spikes, one in every slot.
- R5: When every value of the frame is zero, no channel emits any spike.
- R6: A window lasts exactly `NT` consecutive cycles with `spike_valid` high. Bit i of `spike` set in such a cycle is a spike of channel i in that slot. `spike` is all-zero whenever `spike_valid` is low.
- R7: `window_done` is high for exactly one cycle, the cycle right after the last slot. The block is idle again after it, so `in_ready` stays low until the next `start`.
- R8: A channel whose remaining count equals the number of remaining slots fires in every one of those slots. After the final slot, no channel has a spike left over.
- R9: Placement is a function of `seed` alone for a given frame, so the same seed and frame give identical trains. Each channel derives its own generator state from the seed, so channels with equal values are placed differently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new frame when idle; latches `seed` |
| seed | input | 16 | Seed for the per-channel placement generators |
| in_valid | input | 1 | A frame value is offered on `in_data` |
| in_data | input | VAL_W | Frame value, channel order 0 upward |
| in_ready | output | 1 | High while frame values are being collected |
| spike | output | N_CH | Spike vector of the current slot, bit i for channel i |
| spike_valid | output | 1 | High during each of the `NT` slots of a window |
| window_done | output | 1 | One-cycle pulse after the last slot |

## Verification
The two functions that can fall in the same cycle are the forced spike of a channel whose remaining count equals the slots left, and the close of the window on its last slot. A frame with one non-zero channel provokes this: the channel's count is clamped to `NT`, so it must fire in every slot, including the one just before `window_done`. The bench judges this by requiring a full train of ones on that channel, a window of exactly `NT` slots, and a done pulse on the very next cycle. A round-half tie frame and an all-zero frame are checked the same way, against counts the bench computes itself.

// File: rtl/rse_pkg.sv
package rse_pkg;

    localparam int LFSR_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DIV,
        ST_RUN,
        ST_DONE
    } rse_state_e;

    // Galois LFSR step, maximal-length 16-bit polynomial
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    // Per-channel starting state: seed scrambled by channel number, never zero
    function automatic logic [LFSR_W-1:0] chan_seed(input logic [LFSR_W-1:0] s,
                                                   input int unsigned ch);
        logic [LFSR_W-1:0] t;
        t = s ^ LFSR_W'((ch + 1) * 40503);
        if (t == '0) t = 16'h0001;
        return t;
    endfunction

endpackage

// File: rtl/rse_divider.sv
module rse_divider #(
    parameter int DW = 20,
    parameter int SW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [SW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quot
);
    localparam int CNTW = $clog2(DW + 1);

    logic            busy;
    logic [CNTW-1:0] cnt;
    logic [SW-1:0]   rem;
    logic [DW-1:0]   q;
    logic [SW:0]     trial;

    assign trial = {rem, q[DW-1]};
    assign quot  = q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            rem  <= '0;
            q    <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                q    <= dividend;
                rem  <= '0;
                cnt  <= CNTW'(DW);
                busy <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, divisor}) begin
                    rem <= SW'(trial - {1'b0, divisor});
                    q   <= {q[DW-2:0], 1'b1};
                end else begin
                    rem <= SW'(trial);
                    q   <= {q[DW-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNTW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R3: partial remainder stays below a non-zero divisor
    assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && divisor != '0) |-> (rem < divisor));

endmodule

// File: rtl/rse_channel.sv
module rse_channel #(
    parameter int NT = 128
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      seed_load,
    input  logic [rse_pkg::LFSR_W-1:0] seed_val,
    input  logic                      cnt_load,
    input  logic [$clog2(NT+1)-1:0]   cnt_val,
    input  logic                      step,
    input  logic [$clog2(NT+1)-1:0]   slots_left,
    output logic                      fire
);
    import rse_pkg::*;

    localparam int CW = $clog2(NT + 1);

    logic [LFSR_W-1:0]    lfsr;
    logic [CW-1:0]        rem;
    logic [LFSR_W+CW-1:0] prod;
    logic [CW-1:0]        draw;

    // draw = floor(lfsr * slots_left / 2^LFSR_W), always below slots_left
    assign prod = (LFSR_W + CW)'(lfsr) * (LFSR_W + CW)'(slots_left);
    assign draw = CW'(prod >> LFSR_W);
    assign fire = step && (draw < rem);

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr <= 16'h0001;
            rem  <= '0;
        end else begin
            if (seed_load) lfsr <= seed_val;
            else if (step) lfsr <= lfsr_step(lfsr);
            if (cnt_load) rem <= cnt_val;
            else if (step) rem <= rem - CW'(fire);
        end
    end

    // R8: remaining spikes never outnumber remaining slots
    assert_rem_fits_R8: assert property (@(posedge clk) disable iff (rst)
        step |-> (rem <= slots_left));

    // R8: a channel with as many spikes as slots must fire
    assert_forced_fire_R8: assert property (@(posedge clk) disable iff (rst)
        (step && rem == slots_left && rem != '0) |-> fire);

    // R8: nothing is left over after the final slot
    assert_drained_R8: assert property (@(posedge clk) disable iff (rst)
        (step && slots_left == CW'(1)) |=> (rem == '0));

endmodule

// File: rtl/rate_spike_encoder.sv
module rate_spike_encoder #(
    parameter int N_CH  = 32,
    parameter int VAL_W = 8,
    parameter int NT    = 128,
    parameter int NS    = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      seed,
    input  logic             in_valid,
    input  logic [VAL_W-1:0] in_data,
    output logic             in_ready,
    output logic [N_CH-1:0]  spike,
    output logic             spike_valid,
    output logic             window_done
);
    import rse_pkg::*;

    localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int SUM_W = VAL_W + IDX_W;
    localparam int NSW   = $clog2(NS + 1);
    localparam int DW    = ((NSW > SUM_W) ? NSW : SUM_W) + VAL_W + 1;
    localparam int CW    = $clog2(NT + 1);
    localparam int SLT_W = (NT > 1) ? $clog2(NT) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_CH - 1);
    localparam logic [SLT_W-1:0] SLOT_LAST = SLT_W'(NT - 1);

    rse_state_e       st;
    logic [IDX_W-1:0] idx;
    logic [SUM_W-1:0] sum;
    logic [VAL_W-1:0] vals [N_CH];
    logic [SLT_W-1:0] slot;
    logic             div_pend;
    logic             div_go;
    logic             div_done;
    logic [DW-1:0]    dividend;
    logic [DW-1:0]    quot;
    logic [CW-1:0]    count_q;
    logic [CW-1:0]    slots_left;
    logic             seed_load;
    logic             step;

    assign in_ready    = (st == ST_LOAD);
    assign spike_valid = (st == ST_RUN);
    assign window_done = (st == ST_DONE);
    assign step        = spike_valid;
    assign seed_load   = (st == ST_IDLE) && start;
    assign div_go      = (st == ST_DIV) && !div_pend;
    assign slots_left  = CW'(NT) - CW'(slot);
    assign dividend    = DW'(NS) * DW'(vals[idx]) + DW'(sum >> 1);

    always_comb begin
        if (sum == '0)              count_q = '0;
        else if (quot > DW'(NT))    count_q = CW'(NT);
        else                        count_q = CW'(quot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            idx      <= '0;
            sum      <= '0;
            slot     <= '0;
            div_pend <= 1'b0;
            for (int i = 0; i < N_CH; i++) vals[i] <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_LOAD;
                    idx <= '0;
                    sum <= '0;
                end
                ST_LOAD: if (in_valid) begin
                    vals[idx] <= in_data;
                    sum       <= sum + SUM_W'(in_data);
                    if (idx == IDX_LAST) begin
                        st  <= ST_DIV;
                        idx <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_DIV: begin
                    if (!div_pend) begin
                        div_pend <= 1'b1;
                    end else if (div_done) begin
                        div_pend <= 1'b0;
                        if (idx == IDX_LAST) begin
                            st   <= ST_RUN;
                            idx  <= '0;
                            slot <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    slot <= slot + 1'b1;
                    if (slot == SLOT_LAST) st <= ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    rse_divider #(.DW(DW), .SW(SUM_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (sum),
        .done     (div_done),
        .quot     (quot)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic cnt_load;
        assign cnt_load = (st == ST_DIV) && div_pend && div_done && (idx == IDX_W'(g));
        rse_channel #(.NT(NT)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .seed_load  (seed_load),
            .seed_val   (chan_seed(seed, g)),
            .cnt_load   (cnt_load),
            .cnt_val    (count_q),
            .step       (step),
            .slots_left (slots_left),
            .fire       (spike[g])
        );
    end

    // R6: no spikes outside the window
    assert_quiet_outside_R6: assert property (@(posedge clk) disable iff (rst)
        !spike_valid |-> (spike == '0));

    // R7: done is a single-cycle pulse that directly follows a slot
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        window_done |=> (!window_done && !spike_valid && !in_ready));

    assert_done_after_slot_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(window_done) |-> $past(spike_valid));

    // R2: values are never collected while a window plays
    assert_ready_excl_R2: assert property (@(posedge clk) disable iff (rst)
        spike_valid |=> !in_ready);

endmodule

// File: tb/rate_spike_encoder_test.sv
module rate_spike_encoder_test;
    localparam int N_CH  = 32;
    localparam int VAL_W = 8;
    localparam int NT    = 128;
    localparam int NS    = 2000;
    localparam int NVEC  = 6;

    // {kind[7:0], a[7:0], b[7:0], seed[15:0]}; kind 0: v=(a+b*i)&255, kind 1: ch0=a, ch1=b
    localparam logic [39:0] VEC [NVEC] = '{
        {8'd0, 8'd1,   8'd3,  16'h1234},
        {8'd0, 8'd10,  8'd0,  16'hBEEF},
        {8'd1, 8'd2,   8'd62, 16'h0F0F},
        {8'd1, 8'd0,   8'd200,16'hA5A5},
        {8'd0, 8'd0,   8'd0,  16'h5555},
        {8'd0, 8'd255, 8'd0,  16'h7001}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [15:0]      seed = '0;
    logic             in_valid = 1'b0;
    logic [VAL_W-1:0] in_data = '0;
    logic             in_ready;
    logic [N_CH-1:0]  spike;
    logic             spike_valid;
    logic             window_done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int            cnt   [N_CH];
    logic [NT-1:0] train [N_CH];
    logic [NT-1:0] saved [N_CH];
    int            wlen;
    bit            done_seen;
    bit            done_after_slot;

    always #10 clk = ~clk;

    rate_spike_encoder #(.N_CH(N_CH), .VAL_W(VAL_W), .NT(NT), .NS(NS)) uut (
        .clk(clk), .rst(rst), .start(start), .seed(seed),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .spike(spike), .spike_valid(spike_valid), .window_done(window_done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int vval(input logic [39:0] v, input int i);
        if (v[39:32] == 8'd0) return (int'(v[31:24]) + int'(v[23:16]) * i) & 255;
        if (i == 0) return int'(v[31:24]);
        if (i == 1) return int'(v[23:16]);
        return 0;
    endfunction

    function automatic int exp_cnt(input int v, input int s);
        int q;
        if (s == 0) return 0;
        q = (NS * v + s / 2) / s;
        return (q > NT) ? NT : q;
    endfunction

    // Loads a frame, plays the window; optionally pokes start at slot poke_at
    task automatic run_frame(input logic [39:0] v, input int poke_at);
        bit last_valid;
        seed = v[15:0];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (i % 5 == 4) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = VAL_W'(vval(v, i));
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            cnt[i] = 0;
            train[i] = '0;
        end
        wlen = 0;
        done_seen = 0;
        done_after_slot = 0;
        last_valid = 0;
        for (int t = 0; t < 4000 && !done_seen; t++) begin
            if (spike_valid) begin
                for (int i = 0; i < N_CH; i++) begin
                    cnt[i] += int'(spike[i]);
                    if (wlen < NT) train[i][wlen] = spike[i];
                end
                wlen++;
                start = (wlen == poke_at);
            end else begin
                start = 1'b0;
                check(spike == '0, "R6 quiet outside window", int'(spike), 0);
            end
            if (window_done) begin
                done_seen = 1;
                done_after_slot = last_valid;
            end
            last_valid = spike_valid;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        int s;
        int bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!in_ready && !spike_valid && !window_done && spike == '0, "R1 reset outputs",
              int'({in_ready, spike_valid, window_done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!in_ready && !spike_valid && !window_done, "R1 idle after reset",
              int'({in_ready, spike_valid, window_done}), 0);

        // R2: values offered while idle are not taken
        in_valid = 1'b1;
        in_data  = 8'hFF;
        repeat (4) begin
            @(negedge clk);
            check(!in_ready && !spike_valid, "R2 idle ignores in_valid", int'(in_ready), 0);
        end
        in_valid = 1'b0;

        // Table walk: R3, R4, R5, R6, R7
        for (int n = 0; n < NVEC; n++) begin
            run_frame(VEC[n], (n == 1) ? 50 : 0);
            s = 0;
            for (int i = 0; i < N_CH; i++) s += vval(VEC[n], i);
            bad = 0;
            for (int i = 0; i < N_CH; i++) begin
                if (cnt[i] != exp_cnt(vval(VEC[n], i), s)) begin
                    bad++;
                    $display("FAIL R3 vector %0d ch %0d: actual %0d expected %0d",
                             n, i, cnt[i], exp_cnt(vval(VEC[n], i), s));
                end
            end
            checks++;
            if (bad != 0) fails++;
            check(wlen == NT, "R6 window length", wlen, NT);
            check(done_seen && done_after_slot, "R7 done after last slot",
                  int'(done_after_slot), 1);
            check(!window_done && !in_ready && !spike_valid, "R7 single done pulse",
                  int'({window_done, in_ready, spike_valid}), 0);
            if (n == 0) for (int i = 0; i < N_CH; i++) saved[i] = train[i];
            if (n == 1) begin
                // R2: start poked mid-window changed nothing; R9: equal values placed apart
                check(!in_ready, "R2 start ignored during window", int'(in_ready), 0);
                check(train[0] != train[1], "R9 channels differ", 0, 1);
            end
            if (n == 2) check(cnt[0] == 63, "R3 tie rounds up", cnt[0], 63);
            if (n == 3) begin
                check(cnt[1] == NT, "R4 clamp to window", cnt[1], NT);
                check(train[1] == '1, "R8 forced fire every slot incl. last",
                      int'(train[1][NT-1]), 1);
            end
            if (n == 4) begin
                bad = 0;
                for (int i = 0; i < N_CH; i++) bad += cnt[i];
                check(bad == 0, "R5 zero frame silent", bad, 0);
            end
        end

        // R9: same frame and seed reproduce the trains
        run_frame(VEC[0], 0);
        bad = 0;
        for (int i = 0; i < N_CH; i++) if (train[i] != saved[i]) bad++;
        check(bad == 0, "R9 reproducible with seed", bad, 0);

        // R9: another seed moves spikes of the same frame
        run_frame({VEC[0][39:16], 16'h4321}, 0);
        bad = 0;
        for (int i = 0; i < N_CH; i++) if (train[i] != saved[i]) bad++;
        check(bad != 0, "R9 seed changes placement", bad, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule